// File: doc/BRIEF.md
# SPI Slave with Transmit Holding Register

This block is the slave end of an SPI link. A local processor writes each outgoing word into a holding register. The block moves that word into a shift register and sends it most significant bit first on MISO. Bits arriving on MOSI are shifted into a receive register at the same time. Two mode inputs select the clock polarity (`cpol`) and the clock phase (`cpha`). A word is one, two or three bytes long, chosen by `wlen`. A flag shows the processor when the holding register is free for the next word.

SCK, the active-low slave select `ss_n` and MOSI are all sampled in the system clock domain. Each passes through a two-flop synchronizer, and SCK edges are found by comparing successive synchronized samples. The system clock must run at least four times faster than SCK. The moment the holding register empties depends on `cpha`:

- With `cpha = 0`, the word moves into the shift register only while slave select is released. The master must release and reassert slave select between words.
- With `cpha = 1`, the next word loads as soon as the current one has been fully shifted. Slave select may stay low across any number of words.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, `hold_empty` is 1, `rx_valid` is 0 and `miso_oe` is 0.
- R2: `miso_oe` is 1 only while `ss_n` is low (after synchronization). While `ss_n` is high it is 0, which models a high-impedance MISO.
- R3: With `cpha = 0`, the MSB of the loaded word is on `miso` as soon as `ss_n` falls, before any SCK edge. MOSI is captured on the leading SCK edge, which moves away from the idle level. MISO changes on the trailing edge.
- R4: With `cpha = 0`, the holding register moves into the shift register only while `ss_n` is high. A word written while `ss_n` is low stays pending, and `hold_empty` stays 0, until `ss_n` is released.
- R5: With `cpha = 1`, MISO changes on the leading SCK edge and MOSI is captured on the trailing edge. A pending word loads as soon as the previous word has completed, even with `ss_n` held low. Consecutive words may then be sent without releasing `ss_n`.
- R6: `hold_empty` drops one cycle after `hold_wr`. It returns to 1 one cycle after the word moves into the shift register. A write with `cpha = 1` and an empty shifter therefore gives a one-cycle low pulse.
- R7: `wlen` selects the word length: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 24 bits. The word is taken from the low bits of `hold_data` and sent MSB first.
- R8: After the last capture edge of a word, `rx_valid` pulses for exactly one cycle. `rx_data` then holds the received bits right-aligned, with the bits above the word length cleared. The pulse comes on the third system clock edge after the SCK edge reaches the pin.
- R9: If `ss_n` is released partway through a word, the partial word is discarded. No `rx_valid` pulse is produced, and the untransmitted remainder is never sent.
- R10: When no word has been loaded into the shift register, a transfer sends all zero bits on MISO.
- R11: With `cpol = 1`, SCK idles high. The falling edge is then the leading edge, and every rule above applies with the edge directions swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| wlen | input | 2 | Word length code (0: 8, 1: 16, 2/3: 24 bits) |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | MISO drive enable (0 means high impedance) |
| hold_wr | input | 1 | Processor write strobe for the holding register |
| hold_data | input | 24 | Word to transmit, right-aligned |
| hold_empty | output | 1 | Holding register may be written |
| rx_data | output | 24 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |

## Verification
The bench drives every pin on the falling system clock edge. Each pin change then reaches the synchronizer output after two rising edges, and the edge detector reacts on the third. So `rx_valid` is expected exactly three rising edges after the final capture edge: the bench checks that it is still low at the second following falling edge and high at the third. A holding register write clears `hold_empty` at the next rising edge. A load with `cpha = 1` sets it again one edge later, so flag checks are placed two or four falling edges after the causing event. MISO is sampled eight cycles after each shift edge, just before the master drives the capture edge, which leaves the three-cycle input delay well inside the window.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [1:0] {
    WL_ONE   = 2'd0,
    WL_TWO   = 2'd1,
    WL_THREE = 2'd2,
    WL_ALT   = 2'd3
  } wlen_e;

  // number of bytes in a word for a length code, clamped to the build maximum
  function automatic int unsigned word_bytes(input logic [1:0] code, input int unsigned max_bytes);
    int unsigned b;
    case (wlen_e'(code))
      WL_ONE:  b = 1;
      WL_TWO:  b = 2;
      default: b = 3;
    endcase
    if (b > max_bytes) b = max_bytes;
    return b;
  endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  input  logic active,
  output logic cap_stb,
  output logic shf_stb
);

  logic sck_d;
  logic toggled;
  logic lead;
  logic trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  always_comb begin
    toggled = active & (sck_s ^ sck_d);
    lead    = toggled & (sck_s ^ cpol);     // leaving the idle level
    trail   = toggled & ~(sck_s ^ cpol);    // returning to the idle level
    cap_stb = cpha ? trail : lead;
    shf_stb = cpha ? lead  : trail;
  end

endmodule

// File: rtl/spi_hold_reg.sv
module spi_hold_reg #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic [DW-1:0] hold_q,
  output logic          hold_full
);

  logic [DW-1:0] hold_q_n;
  logic          full_n;

  always_comb begin
    hold_q_n = hold_q;
    full_n   = hold_full;
    if (wr) begin
      hold_q_n = wdata;
      full_n   = 1'b1;
    end else if (take) begin
      full_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (wr) hold_q <= hold_q_n;
      hold_full <= full_n;
    end
  end

endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
  parameter int unsigned DW = 24,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpha,
  input  logic [CW-1:0] nbits,
  input  logic          ss_act,
  input  logic          cap_stb,
  input  logic          shf_stb,
  input  logic          mosi_s,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_q,
  output logic          load,
  output logic          out_bit,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid
);

  localparam logic [CW-1:0] DWC = CW'(DW);

  logic [DW-1:0] tx_sr,   tx_sr_n;
  logic [DW-1:0] rx_sr,   rx_sr_n;
  logic [DW-1:0] rx_data_n;
  logic [CW-1:0] cnt,     cnt_n;
  logic          sr_full, sr_full_n;
  logic          out_n,   rx_valid_n;
  logic [DW-1:0] aligned, mask, rx_next;
  logic          last_bit, busy_edge;

  always_comb begin
    aligned   = hold_q << (DWC - nbits);
    mask      = {DW{1'b1}} >> (DWC - nbits);
    rx_next   = {rx_sr[DW-2:0], mosi_s};
    last_bit  = (cnt == nbits - 1'b1);
    busy_edge = ss_act & (cap_stb | shf_stb);
    load      = hold_full & ~sr_full & (cnt == '0) & (cpha ? ~busy_edge : ~ss_act);
  end

  always_comb begin
    tx_sr_n    = tx_sr;
    rx_sr_n    = rx_sr;
    rx_data_n  = rx_data;
    cnt_n      = cnt;
    sr_full_n  = sr_full;
    out_n      = out_bit;
    rx_valid_n = 1'b0;
    if (!ss_act && cnt != '0) begin
      // select released mid-word: drop the partial word
      cnt_n     = '0;
      sr_full_n = 1'b0;
      tx_sr_n   = '0;
      out_n     = 1'b0;
    end else if (load) begin
      sr_full_n = 1'b1;
      if (cpha) begin
        tx_sr_n = aligned;
      end else begin
        tx_sr_n = aligned << 1;
        out_n   = aligned[DW-1];
      end
    end else if (!ss_act && !sr_full) begin
      tx_sr_n = '0;
      out_n   = 1'b0;
    end else if (ss_act) begin
      if (shf_stb) begin
        out_n   = tx_sr[DW-1];
        tx_sr_n = tx_sr << 1;
      end
      if (cap_stb) begin
        rx_sr_n = rx_next;
        if (last_bit) begin
          cnt_n      = '0;
          sr_full_n  = 1'b0;
          rx_valid_n = 1'b1;
          rx_data_n  = rx_next & mask;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_data  <= '0;
      cnt      <= '0;
      sr_full  <= 1'b0;
      out_bit  <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      tx_sr    <= tx_sr_n;
      rx_sr    <= rx_sr_n;
      rx_data  <= rx_data_n;
      cnt      <= cnt_n;
      sr_full  <= sr_full_n;
      out_bit  <= out_n;
      rx_valid <= rx_valid_n;
    end
  end

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8

  AST_CNT_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < nbits); // R7

endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned MAX_BYTES = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpol,
  input  logic                        cpha,
  input  logic [1:0]                  wlen,
  input  logic                        sck,
  input  logic                        ss_n,
  input  logic                        mosi,
  output logic                        miso,
  output logic                        miso_oe,
  input  logic                        hold_wr,
  input  logic [BYTE_W*MAX_BYTES-1:0] hold_data,
  output logic                        hold_empty,
  output logic [BYTE_W*MAX_BYTES-1:0] rx_data,
  output logic                        rx_valid
);

  import spi_hold_pkg::*;

  localparam int unsigned DW = BYTE_W * MAX_BYTES;
  localparam int unsigned CW = $clog2(DW + 1);

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic [2:0]    pins_s;
  logic          sck_s, ss_n_s, mosi_s, ss_act;
  logic          cap_stb, shf_stb, load, hold_full;
  logic [DW-1:0] hold_q;
  logic [CW-1:0] nbits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  spi_hold_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({sck, ss_n, mosi}),
    .q    (pins_s)
  );

  always_comb begin
    sck_s  = pins_s[2];
    ss_n_s = pins_s[1];
    mosi_s = pins_s[0];
    ss_act = ~ss_n_s;
    nbits  = CW'(word_bytes(wlen, MAX_BYTES) * BYTE_W);
  end

  spi_hold_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sck_s  (sck_s),
    .cpol   (cpol),
    .cpha   (cpha),
    .active (ss_act),
    .cap_stb(cap_stb),
    .shf_stb(shf_stb)
  );

  spi_hold_reg #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr       (hold_wr),
    .wdata    (hold_data),
    .take     (load),
    .hold_q   (hold_q),
    .hold_full(hold_full)
  );

  spi_hold_shift #(.DW(DW), .CW(CW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cpha     (cpha),
    .nbits    (nbits),
    .ss_act   (ss_act),
    .cap_stb  (cap_stb),
    .shf_stb  (shf_stb),
    .mosi_s   (mosi_s),
    .hold_full(hold_full),
    .hold_q   (hold_q),
    .load     (load),
    .out_bit  (miso),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  assign hold_empty = ~hold_full;
  assign miso_oe    = ss_act;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_wr |=> !hold_empty); // R6

  AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(hold_empty) |-> $past(hold_wr)); // R6

  AST_PHASE0_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(hold_empty) && !cpha && $stable(cpha)) |-> $past(ss_n_s)); // R4

endmodule

// File: tb/spi_hold_slave_test.sv
module spi_hold_slave_test;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpol, cpha;
  logic [1:0]  wlen;
  logic        sck, ss_n, mosi;
  logic        miso, miso_oe;
  logic        hold_wr;
  logic [23:0] hold_data;
  logic        hold_empty;
  logic [23:0] rx_data;
  logic        rx_valid;

  int n_chk = 0;
  int n_bad = 0;
  int rx_cnt = 0;
  logic [23:0] rx_last = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_hold_slave uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .wlen(wlen),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .hold_wr(hold_wr), .hold_data(hold_data), .hold_empty(hold_empty),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic [1:0] wl);
    @(negedge clk);
    ss_n = 1'b1; cpol = p; cpha = h; wlen = wl; sck = p;
    cyc(6);
  endtask

  task automatic write_hold(input logic [23:0] d);
    @(negedge clk);
    hold_wr = 1'b1; hold_data = d;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  // master side of one word; returns the bits seen on MISO
  task automatic spi_word(input int nb, input logic [23:0] mo, output logic [23:0] mi, output int oe_bad);
    mi = '0; oe_bad = 0;
    if (!cpha) begin
      @(negedge clk); mosi = mo[nb-1];
      for (int i = 0; i < nb; i++) begin
        cyc(H);
        mi = {mi[22:0], miso};
        if (!miso_oe) oe_bad++;
        @(negedge clk); sck = ~cpol;
        cyc(H);
        @(negedge clk); sck = cpol;
        if (i < nb - 1) mosi = mo[nb-2-i];
      end
    end else begin
      for (int i = 0; i < nb; i++) begin
        @(negedge clk); sck = ~cpol; mosi = mo[nb-1-i];
        cyc(H);
        mi = {mi[22:0], miso};
        if (!miso_oe) oe_bad++;
        @(negedge clk); sck = cpol;
        if (i < nb - 1) cyc(H);
      end
      cyc(2);
      chk(rx_valid == 1'b0, "R8 strobe not early", {23'd0, rx_valid}, 24'd0);
      cyc(1);
      chk(rx_valid == 1'b1, "R8 strobe on third edge", {23'd0, rx_valid}, 24'd1);
    end
  endtask

  task automatic t_reset;
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", {23'd0, hold_empty}, 24'd1);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", {23'd0, rx_valid}, 24'd0);
    chk(miso_oe == 1'b0, "R1 R2 miso_oe with select high", {23'd0, miso_oe}, 24'd0);
  endtask

  task automatic t_phase0_byte(input logic p, input logic [7:0] tx, input logic [7:0] rx);
    logic [23:0] got; int bad; int base;
    set_mode(p, 1'b0, 2'd0);
    write_hold({16'hABCD, tx});
    cyc(2);
    chk(hold_empty == 1'b1, "R6 R4 loaded while select high", {23'd0, hold_empty}, 24'd1);
    base = rx_cnt;
    @(negedge clk); ss_n = 1'b0;
    cyc(3);
    chk(miso_oe == 1'b1, "R2 drive enabled under select", {23'd0, miso_oe}, 24'd1);
    chk(miso == tx[7], "R3 MSB before first edge", {23'd0, miso}, {23'd0, tx[7]});
    spi_word(8, {16'd0, rx}, got, bad);
    chk(got == {16'd0, tx}, p ? "R3 R11 R7 phase0 miso word cpol1" : "R3 R7 phase0 miso word", got, {16'd0, tx});
    chk(bad == 0, "R2 enable during word", bad, 0);
    cyc(6);
    chk(rx_cnt == base + 1, "R8 one strobe per word", rx_cnt, base + 1);
    chk(rx_last == {16'd0, rx}, "R8 received byte right-aligned", rx_last, {16'd0, rx});
    @(negedge clk); ss_n = 1'b1;
    cyc(4);
    chk(miso_oe == 1'b0, "R2 enable off after release", {23'd0, miso_oe}, 24'd0);
  endtask

  task automatic t_phase0_pending;
    logic [23:0] got; int bad;
    set_mode(1'b1, 1'b0, 2'd1);
    @(negedge clk); ss_n = 1'b0;
    cyc(4);
    write_hold(24'h00_9E37);
    cyc(5);
    chk(hold_empty == 1'b0, "R4 no load while selected", {23'd0, hold_empty}, 24'd0);
    spi_word(16, 24'h00_1234, got, bad);
    chk(got == 24'd0, "R10 empty shifter sends zeros", got, 24'd0);
    chk(hold_empty == 1'b0, "R4 still pending after word", {23'd0, hold_empty}, 24'd0);
    cyc(6);
    chk(rx_last == 24'h00_1234, "R7 R8 16-bit receive", rx_last, 24'h00_1234);
    @(negedge clk); ss_n = 1'b1;
    cyc(5);
    chk(hold_empty == 1'b1, "R4 load after release", {23'd0, hold_empty}, 24'd1);
    @(negedge clk); ss_n = 1'b0;
    cyc(H);
    spi_word(16, 24'h00_5A5A, got, bad);
    chk(got == 24'h00_9E37, "R4 R11 pending word sent next frame", got, 24'h00_9E37);
    @(negedge clk); ss_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_phase1_stream(input logic p, input logic [1:0] wl);
    logic [23:0] got; int bad; int base;
    set_mode(p, 1'b1, wl);
    @(negedge clk); hold_wr = 1'b1; hold_data = 24'hC0FFEE;
    @(negedge clk); hold_wr = 1'b0;
    chk(hold_empty == 1'b0, "R6 flag drops after write", {23'd0, hold_empty}, 24'd0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R6 R5 flag back after load", {23'd0, hold_empty}, 24'd1);
    write_hold(24'h135724);
    cyc(4);
    chk(hold_empty == 1'b0, "R5 waits for shifter", {23'd0, hold_empty}, 24'd0);
    base = rx_cnt;
    @(negedge clk); ss_n = 1'b0;
    cyc(H);
    spi_word(24, 24'h8001F0, got, bad);
    chk(got == 24'hC0FFEE, "R5 R7 first 24-bit word", got, 24'hC0FFEE);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R5 R6 reload under select", {23'd0, hold_empty}, 24'd1);
    cyc(H);
    spi_word(24, 24'h7E0001, got, bad);
    chk(got == 24'h135724, p ? "R5 R11 second word cpol1" : "R5 second word", got, 24'h135724);
    cyc(3);
    chk(rx_cnt == base + 2, "R8 two strobes", rx_cnt, base + 2);
    chk(rx_last == 24'h7E0001, "R8 second receive", rx_last, 24'h7E0001);
    @(negedge clk); ss_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_abort;
    logic [23:0] got; int bad; int base;
    set_mode(1'b0, 1'b0, 2'd0);
    write_hold(24'h0000C3);
    cyc(3);
    base = rx_cnt;
    @(negedge clk); ss_n = 1'b0; mosi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc(H);
      @(negedge clk); sck = 1'b1;
      cyc(H);
      @(negedge clk); sck = 1'b0;
    end
    @(negedge clk); ss_n = 1'b1;
    cyc(10);
    chk(rx_cnt == base, "R9 no strobe for partial word", rx_cnt, base);
    @(negedge clk); ss_n = 1'b0;
    cyc(H);
    spi_word(8, 24'h000066, got, bad);
    chk(got == 24'd0, "R9 R10 remainder dropped", got, 24'd0);
    cyc(6);
    chk(rx_last == 24'h000066 && rx_cnt == base + 1, "R9 next frame clean", rx_last, 24'h000066);
    @(negedge clk); ss_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; wlen = 2'd0;
    sck = 1'b0; ss_n = 1'b1; mosi = 1'b0; hold_wr = 1'b0; hold_data = '0;
    cyc(5);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_phase0_byte(1'b0, 8'hA5, 8'h3C);
    t_phase0_byte(1'b1, 8'h96, 8'hF1);
    t_phase0_pending();
    t_phase1_stream(1'b0, 2'd2);
    t_phase1_stream(1'b1, 2'd3);
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule